// File: doc/BRIEF.md
# Serial DAC Command Master with Self-Check Initialization

This block drives a register-based digital-to-analog converter over a four-wire serial link: a clock that rests high, an active-low frame select, a command line out and a data line back. Every transfer is one 24-bit frame, sent most significant bit first. The bits coming back on the return line during the same frame are collected into a 24-bit response.

After reset a small sequencer runs three frames on its own. The first writes the configuration register with the output buffer enabled and binary offset coding selected. The second asks for that register to be read back. The third is an all-zero filler frame, which carries the readback home. The sequencer compares the returned word with the value it wrote and reports the result. Only after this does the block accept output codes from its write port. Each code is sent as an output-register write frame.

The clock half-period and the select-to-first-edge setup are counted in system clock cycles and set by parameters.

Top module: `dac_serial_ctrl`

## Requirements
- R1: While reset is held, and whenever no frame is active, `dac_sclk` is high and `dac_sync_n` is high. During reset `init_done`, `init_ok` and `wr_ready` are low.
- R2: Each frame holds `dac_sync_n` low for exactly 24 serial clock cycles. `dac_mosi` changes only on a falling `dac_sclk` edge, carrying frame bit 23 first and bit 0 last, so the device can take it on the rising edge.
- R3: `dac_sync_n` falls exactly `SETUP_DIV` system cycles before the first falling `dac_sclk` edge. Every low and every high half of `dac_sclk` inside a frame lasts exactly `HALF_DIV` system cycles.
- R4: `dac_miso` is sampled at the end of each low half and shifted in most significant bit first. When the frame ends, `rsp_valid` pulses for one cycle and `rsp_data` holds the 24 bits received in that frame.
- R5: After reset the first three frames are, in order: 0x200012 (bit 21 marks the configuration write; payload bit 1 enables the buffer and bit 4 selects binary offset), 0xA00000 (bit 23 requests a read of the register addressed by bit 21), and 0x000000 (the filler frame).
- R6: `init_done` rises once the filler frame ends and then stays high until reset. `init_ok` is high only if the 24-bit response to the filler frame equals 0x000012; otherwise it stays low.
- R7: While `init_done` is low, `wr_ready` is low and `wr_valid` starts no frame.
- R8: An accepted write of `wr_code` sends the frame 0x100000 | `wr_code`: bit 20 is set and the 20-bit code sits in bits 19:0.
- R9: Between two frames `dac_sync_n` stays high for at least `HALF_DIV` system cycles.
- R10: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. Each acceptance starts exactly one frame, and `wr_ready` is low from the following cycle until that frame and its trailing gap are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Request to send an output code |
| wr_code | input | 20 | Output code to load into the converter |
| wr_ready | output | 1 | High when a write request can be taken |
| rsp_valid | output | 1 | One-cycle pulse at the end of every frame |
| rsp_data | output | 24 | Bits received during the last finished frame |
| init_done | output | 1 | Initialization sequence has finished |
| init_ok | output | 1 | Readback matched the configuration value |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_mosi | output | 1 | Serial command data to the converter |
| dac_miso | input | 1 | Serial data returned by the converter |

## Verification
The write port and the initialization sequencer both want the shifter. The moment the sequencer hands over is where they meet: the last filler frame ends, `init_done` rises and a pending write can start. The bench provokes this by holding `wr_valid` high with a known code from reset onward. It then judges the outcome from the frames captured by a device model. There must be exactly three sequencer frames before `init_done`, and the held code must arrive as the fourth frame, with nothing lost and nothing sent twice. A second run makes the model corrupt its readback, and `init_ok` must stay low while writes still go through.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int FRAME_W      = 24;
    localparam int CODE_W       = 20;
    localparam int CMD_RD_POS   = 23;
    localparam int CMD_CFG_POS  = 21;
    localparam int CMD_OUT_POS  = 20;
    localparam int CFG_BUF_POS  = 1;
    localparam int CFG_BOFS_POS = 4;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CODE_W-1:0]  code_t;

    localparam frame_t ONE_F     = frame_t'(1);
    localparam frame_t CFG_VALUE = (ONE_F << CFG_BUF_POS) | (ONE_F << CFG_BOFS_POS);

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_LOW,
        SH_HIGH,
        SH_GAP
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_CFG,
        SQ_READ,
        SQ_NOP,
        SQ_RUN
    } sq_state_e;

    function automatic frame_t out_frame(input code_t code);
        return (ONE_F << CMD_OUT_POS) | frame_t'(code);
    endfunction

    function automatic frame_t seq_frame(input sq_state_e st);
        frame_t f;
        unique case (st)
            SQ_CFG:  f = (ONE_F << CMD_CFG_POS) | CFG_VALUE;
            SQ_READ: f = (ONE_F << CMD_RD_POS) | (ONE_F << CMD_CFG_POS);
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
    import dac_ctrl_pkg::*;
#(
    parameter int HALF_DIV  = 125,
    parameter int SETUP_DIV = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  frame_t frame_i,
    output logic   ready_o,
    output logic   done_o,
    output frame_t rx_o,
    output logic   sclk_o,
    output logic   sync_n_o,
    output logic   mosi_o,
    input  logic   miso_i
);

    localparam int MAXD = (HALF_DIV > SETUP_DIV) ? HALF_DIV : SETUP_DIV;
    localparam int CW   = $clog2(MAXD + 1);
    localparam int BW   = $clog2(FRAME_W);
    localparam logic [CW-1:0] HALF_LOAD  = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] SETUP_LOAD = CW'(SETUP_DIV - 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_W - 1);

    typedef struct packed {
        sh_state_e       state;
        logic [CW-1:0]   cnt;
        logic [BW-1:0]   bitn;
        frame_t          tx;
        frame_t          rx;
        logic            sclk;
        logic            sync_n;
        logic            mosi;
        logic            done;
    } sh_regs_t;

    localparam sh_regs_t SH_RESET = '{
        state:  SH_IDLE,
        cnt:    '0,
        bitn:   '0,
        tx:     '0,
        rx:     '0,
        sclk:   1'b1,
        sync_n: 1'b1,
        mosi:   1'b0,
        done:   1'b0
    };

    sh_regs_t sh_d, sh_q;
    logic     cnt_zero;

    assign cnt_zero = (sh_q.cnt == '0);

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        unique case (sh_q.state)
            SH_IDLE: begin
                if (start_i) begin
                    sh_d.state  = SH_SETUP;
                    sh_d.tx     = frame_i;
                    sh_d.rx     = '0;
                    sh_d.sync_n = 1'b0;
                    sh_d.cnt    = SETUP_LOAD;
                    sh_d.bitn   = '0;
                end
            end
            SH_SETUP: begin
                if (cnt_zero) begin
                    sh_d.state = SH_LOW;
                    sh_d.sclk  = 1'b0;
                    sh_d.mosi  = sh_q.tx[FRAME_W-1];
                    sh_d.cnt   = HALF_LOAD;
                end else begin
                    sh_d.cnt = sh_q.cnt - 1'b1;
                end
            end
            SH_LOW: begin
                if (cnt_zero) begin
                    sh_d.rx    = {sh_q.rx[FRAME_W-2:0], miso_i};
                    sh_d.sclk  = 1'b1;
                    sh_d.state = SH_HIGH;
                    sh_d.cnt   = HALF_LOAD;
                end else begin
                    sh_d.cnt = sh_q.cnt - 1'b1;
                end
            end
            SH_HIGH: begin
                if (cnt_zero) begin
                    if (sh_q.bitn == LAST_BIT) begin
                        sh_d.state  = SH_GAP;
                        sh_d.sync_n = 1'b1;
                        sh_d.mosi   = 1'b0;
                        sh_d.done   = 1'b1;
                        sh_d.cnt    = HALF_LOAD;
                    end else begin
                        sh_d.bitn  = sh_q.bitn + 1'b1;
                        sh_d.tx    = {sh_q.tx[FRAME_W-2:0], 1'b0};
                        sh_d.sclk  = 1'b0;
                        sh_d.mosi  = sh_q.tx[FRAME_W-2];
                        sh_d.state = SH_LOW;
                        sh_d.cnt   = HALF_LOAD;
                    end
                end else begin
                    sh_d.cnt = sh_q.cnt - 1'b1;
                end
            end
            SH_GAP: begin
                if (cnt_zero) sh_d.state = SH_IDLE;
                else          sh_d.cnt   = sh_q.cnt - 1'b1;
            end
            default: sh_d = SH_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= SH_RESET;
        else        sh_q <= sh_d;
    end

    assign ready_o  = (sh_q.state == SH_IDLE);
    assign done_o   = sh_q.done;
    assign rx_o     = sh_q.rx;
    assign sclk_o   = sh_q.sclk;
    assign sync_n_o = sh_q.sync_n;
    assign mosi_o   = sh_q.mosi;

endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
    import dac_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sh_ready_i,
    input  logic   sh_done_i,
    input  frame_t sh_rx_i,
    output logic   start_o,
    output frame_t frame_o,
    output logic   init_done_o,
    output logic   init_ok_o
);

    typedef struct packed {
        sq_state_e state;
        logic      pending;
        logic      ok;
    } sq_regs_t;

    localparam sq_regs_t SQ_RESET = '{state: SQ_CFG, pending: 1'b0, ok: 1'b0};

    sq_regs_t sq_d, sq_q;
    logic     running;

    assign running = (sq_q.state != SQ_RUN);
    assign start_o = running && !sq_q.pending && sh_ready_i;
    assign frame_o = seq_frame(sq_q.state);

    always_comb begin
        sq_d = sq_q;
        if (start_o) begin
            sq_d.pending = 1'b1;
        end else if (sq_q.pending && sh_done_i) begin
            sq_d.pending = 1'b0;
            unique case (sq_q.state)
                SQ_CFG:  sq_d.state = SQ_READ;
                SQ_READ: sq_d.state = SQ_NOP;
                SQ_NOP: begin
                    sq_d.state = SQ_RUN;
                    sq_d.ok    = (sh_rx_i == CFG_VALUE);
                end
                default: sq_d.state = SQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= SQ_RESET;
        else        sq_q <= sq_d;
    end

    assign init_done_o = !running;
    assign init_ok_o   = sq_q.ok;

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int HALF_DIV  = 125,
    parameter int SETUP_DIV = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [19:0] wr_code,
    output logic        wr_ready,
    output logic        rsp_valid,
    output logic [23:0] rsp_data,
    output logic        init_done,
    output logic        init_ok,
    output logic        dac_sclk,
    output logic        dac_sync_n,
    output logic        dac_mosi,
    input  logic        dac_miso
);

    logic   sh_start, sh_ready, sh_done;
    frame_t sh_frame, sh_rx, seq_frame_w;
    logic   seq_start;

    dac_init_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sh_ready_i  (sh_ready),
        .sh_done_i   (sh_done),
        .sh_rx_i     (sh_rx),
        .start_o     (seq_start),
        .frame_o     (seq_frame_w),
        .init_done_o (init_done),
        .init_ok_o   (init_ok)
    );

    // R7: the write port only reaches the shifter after initialization.
    assign wr_ready = init_done && sh_ready;
    assign sh_start = seq_start || (wr_valid && wr_ready);
    assign sh_frame = init_done ? out_frame(wr_code) : seq_frame_w;

    dac_frame_shifter #(
        .HALF_DIV  (HALF_DIV),
        .SETUP_DIV (SETUP_DIV)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sh_start),
        .frame_i  (sh_frame),
        .ready_o  (sh_ready),
        .done_o   (sh_done),
        .rx_o     (sh_rx),
        .sclk_o   (dac_sclk),
        .sync_n_o (dac_sync_n),
        .mosi_o   (dac_mosi),
        .miso_i   (dac_miso)
    );

    assign rsp_valid = sh_done;
    assign rsp_data  = sh_rx;

endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_ready,
    input logic rsp_valid,
    input logic init_done,
    input logic init_ok,
    input logic dac_sclk,
    input logic dac_sync_n,
    input logic dac_mosi
);

    p_idle_sclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> dac_sclk);

    p_mosi_held_while_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk) && !dac_sync_n && !$past(dac_sync_n)) |-> $stable(dac_mosi));

    p_rsp_at_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(dac_sync_n));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_ok |-> init_done);

    p_no_write_before_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !wr_ready);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sync_n |-> !wr_ready);

endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .rsp_valid  (rsp_valid),
    .init_done  (init_done),
    .init_ok    (init_ok),
    .dac_sclk   (dac_sclk),
    .dac_sync_n (dac_sync_n),
    .dac_mosi   (dac_mosi)
);

// File: tb/test_dac_serial_ctrl.sv
`timescale 1ns/1ps
module test_dac_serial_ctrl;

    localparam int HALF  = 2;
    localparam int SETUP = 1;
    localparam logic [23:0] RSP_MIX = 24'h5A3C96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_code = '0;
    logic        wr_ready, rsp_valid, init_done, init_ok;
    logic [23:0] rsp_data;
    logic        dac_sclk, dac_sync_n, dac_mosi;
    logic        dac_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dac_serial_ctrl #(.HALF_DIV(HALF), .SETUP_DIV(SETUP)) i_dac_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
        .wr_ready(wr_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .init_done(init_done), .init_ok(init_ok), .dac_sclk(dac_sclk),
        .dac_sync_n(dac_sync_n), .dac_mosi(dac_mosi), .dac_miso(dac_miso)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Device model: shifts in on rising sclk, drives out on falling sclk.
    logic [23:0] frames  [128];
    logic [23:0] exp_rsp [128];
    int          nbits   [128];
    int          nfr = 0;
    int          bitcnt = 0;
    bit          in_frame = 0;
    bit          corrupt = 0;
    logic [23:0] rx_sh = '0;
    logic [23:0] out_sh = '0;
    logic [19:0] cfg_reg = '0;

    always @(negedge dac_sync_n) if (rst_n) begin
        in_frame = 1;
        bitcnt   = 0;
        rx_sh    = '0;
    end

    always @(negedge dac_sclk) if (in_frame && bitcnt < 24)
        dac_miso <= out_sh[23 - bitcnt];

    always @(posedge dac_sclk) if (in_frame) begin
        rx_sh = {rx_sh[22:0], dac_mosi};
        bitcnt++;
    end

    always @(posedge dac_sync_n) if (in_frame) begin
        in_frame       = 0;
        frames[nfr]    = rx_sh;
        exp_rsp[nfr]   = out_sh;
        nbits[nfr]     = bitcnt;
        nfr++;
        if (rx_sh[23])      out_sh = {4'h0, cfg_reg} ^ (corrupt ? 24'h000001 : 24'h0);
        else                out_sh = rx_sh ^ RSP_MIX;
        if (rx_sh[21] && !rx_sh[23]) cfg_reg = rx_sh[19:0];
    end

    // Timing monitor for R2, R3 and R9.
    bit   mon_en = 0;
    bit   first_hi = 0;
    bit   seen_frame = 0;
    int   run = 0;
    logic p_sclk = 1'b1, p_sync = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) if (mon_en) begin
        if ({dac_sclk, dac_sync_n} != {p_sclk, p_sync}) begin
            case ({p_sclk, p_sync})
                2'b10: if (first_hi) chk(run == SETUP, "R3 sync setup", run, SETUP);
                       else          chk(run == HALF, "R3 high half", run, HALF);
                2'b00: chk(run == HALF, "R3 low half", run, HALF);
                2'b11: if (seen_frame) chk(run >= HALF, "R9 gap", run, HALF);
                default: ;
            endcase
            if ({p_sclk, p_sync} == 2'b10) first_hi = 0;
            if (p_sync && !dac_sync_n) first_hi = 1;
            if (!p_sync && dac_sync_n) seen_frame = 1;
            run = 1;
        end else begin
            run++;
        end
        if (!dac_sync_n && !p_sync && dac_mosi !== p_mosi)
            chk(p_sclk && !dac_sclk, "R2 mosi change off falling edge", dac_sclk, 0);
        p_sclk = dac_sclk;
        p_sync = dac_sync_n;
        p_mosi = dac_mosi;
    end

    task automatic do_reset();
        rst_n    = 1'b0;
        wr_valid = 1'b0;
        mon_en   = 0;
        repeat (4) @(negedge clk);
        nfr = 0; in_frame = 0; out_sh = '0; cfg_reg = '0;
        chk(dac_sclk == 1'b1,   "R1 sclk in reset", dac_sclk, 1);
        chk(dac_sync_n == 1'b1, "R1 sync in reset", dac_sync_n, 1);
        chk(init_done == 1'b0,  "R1 init_done in reset", init_done, 0);
        chk(init_ok == 1'b0,    "R1 init_ok in reset", init_ok, 0);
        chk(wr_ready == 1'b0,   "R1 wr_ready in reset", wr_ready, 0);
        first_hi = 0; seen_frame = 0; run = 0;
        p_sclk = 1'b1; p_sync = 1'b1; p_mosi = 1'b0;
        mon_en = 1;
        rst_n  = 1'b1;
    endtask

    task automatic do_write(input logic [19:0] code);
        int idx;
        while (!wr_ready) @(negedge clk);
        idx      = nfr;
        wr_valid = 1'b1;
        wr_code  = code;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready == 1'b0, "R10 ready drops after accept", wr_ready, 0);
        while (!rsp_valid) @(negedge clk);
        chk(nfr == idx + 1, "R10 one frame per accept", nfr, idx + 1);
        chk(frames[idx] == (24'h100000 | {4'h0, code}), "R8 write frame", frames[idx],
            24'h100000 | {4'h0, code});
        chk(nbits[idx] == 24, "R2 frame length", nbits[idx], 24);
        chk(rsp_data == exp_rsp[idx], "R4 response", rsp_data, exp_rsp[idx]);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R7: a write held from reset must wait for the init sequence.
        wr_valid = 1'b1;
        wr_code  = 20'hABCDE;
        while (!init_done) begin
            @(negedge clk);
            if (!init_done) chk(wr_ready == 1'b0, "R7 ready before init", wr_ready, 0);
        end
        chk(nfr == 3, "R7 no early frame", nfr, 3);
        chk(frames[0] == 24'h200012, "R5 config write", frames[0], 24'h200012);
        chk(frames[1] == 24'hA00000, "R5 read request", frames[1], 24'hA00000);
        chk(frames[2] == 24'h000000, "R5 filler", frames[2], 24'h000000);
        for (int i = 0; i < 3; i++) chk(nbits[i] == 24, "R2 init frame length", nbits[i], 24);
        chk(init_ok == 1'b1, "R6 init_ok on match", init_ok, 1);
        chk(rsp_data == 24'h000012, "R4 readback data", rsp_data, 24'h000012);
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(nfr == 4, "R10 held write sent once", nfr, 4);
        chk(frames[3] == 24'h1ABCDE, "R8 held write frame", frames[3], 24'h1ABCDE);
        chk(rsp_data == exp_rsp[3], "R4 held write response", rsp_data, exp_rsp[3]);

        for (int i = 0; i < 20; i++) begin
            do_write(20'(1) << i);
            do_write(~(20'(1) << i));
        end
        for (int k = 0; k < 8; k++) do_write(20'((k * 32'h1B3D7 + 5) & 32'hFFFFF));
        do_write(20'h00000);
        do_write(20'hFFFFF);
        chk(init_done == 1'b1, "R6 init_done sticky", init_done, 1);

        // R6: corrupted readback must leave init_ok low.
        corrupt = 1;
        do_reset();
        while (!init_done) @(negedge clk);
        chk(init_ok == 1'b0, "R6 init_ok on mismatch", init_ok, 0);
        chk(rsp_data == 24'h000013, "R4 corrupted readback", rsp_data, 24'h000013);
        do_write(20'h00001);
        chk(init_ok == 1'b0, "R6 init_ok stays low", init_ok, 0);
        corrupt = 0;

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule